// File: doc/BRIEF.md
# Fracturable Lookup-Table Logic Cell

This block models one logic cell of a soft programmable fabric. A single 64-bit truth table can be read as one six-input function or as two smaller functions. Eight data lines feed it, and it has two result paths, top and bottom. Each path ends in a D flip-flop on the shared cell clock, and a per-path bypass bit can route the path's combinational value around that flip-flop. A static configuration word selects the mode and the input pair, and sets the bypass and packing bits. When a path's flip-flop is left idle by the chosen function, it can instead capture a spare data line directly.

The configuration is checked every cycle. An inconsistent setting raises an error flag and forces both outputs low. The flip-flops keep loading while the flag is raised. The cell reset is asynchronous and active-low, and it is released on the clock through a short synchronizer.

Top module: `frac_lut_cell`

## Requirements
- R1: While `rst_n` is low, both flip-flops stay cleared, so with both bypass bits at 0 the outputs read 0 whatever the mask and data.
- R2: Mode 0 (cfg_mode=0) with cfg_pair_sel=0 is the whole-table mode. The top path result is mask bit {f0,e0,d,c,b,a}, with `in_a` as the least significant index bit.
- R3: Mode 0 with cfg_pair_sel=1 is also the whole-table mode. The bottom path result is mask bit {f1,e1,d,c,b,a}.
- R4: In mode 0 without packing, the path that the pair select does not choose carries 0.
- R5: Mode 1 is the split-into-two-five-input-functions mode. The top path reads mask bit {e0,d,c,b,a}, and the bottom path reads mask bit 32+{f1,e1,f0,b,a}, so lines a and b are shared.
- R6: Mode 2 is the four-plus-five-input mode. The top path is as in R5. The bottom path reads mask bit 32+{f1,e1,f0,s}, where s is `in_b` when cfg_share_b=1 and `in_a` otherwise.
- R7: Mode 3 is the twin six-input mode with one table. The top path reads mask bit {f0,e0,d,c,b,a} and the bottom path reads mask bit {f1,e1,d,c,b,a}.
- R8: Bit 0 of `cfg_bypass` and `cfg_pack` belongs to the top path and bit 1 to the bottom path. A bypassed path shows its value in the same cycle, and its flip-flop holds. A registered path shows the value captured at the previous clock edge.
- R9: `cfg_pack[0]`, legal only in mode 0 with cfg_pair_sel=1, makes the top flip-flop capture `in_e0` instead of the path result.
- R10: `cfg_pack[1]`, legal only in mode 0 with cfg_pair_sel=0 and the top path bypassed, makes the bottom flip-flop capture `in_f1`.
- R11: Any of these raises `cfg_err` and drives both outputs to 0: a pack bit outside its legal setting, or a pack bit together with the bypass bit of the same path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Data line a, index bit 0 |
| in_b | input | 1 | Data line b, index bit 1 |
| in_c | input | 1 | Data line c |
| in_d | input | 1 | Data line d |
| in_e0 | input | 1 | Data line e0 |
| in_f0 | input | 1 | Data line f0 |
| in_e1 | input | 1 | Data line e1 |
| in_f1 | input | 1 | Data line f1 |
| cfg_mask | input | 64 | Truth-table mask |
| cfg_mode | input | 2 | Mode: 0 whole, 1 dual five, 2 four plus five, 3 twin six |
| cfg_pair_sel | input | 1 | Mode 0 upper input pair: 0 e0/f0, 1 e1/f1 |
| cfg_share_b | input | 1 | Mode 2 shared line: 0 a, 1 b |
| cfg_bypass | input | 2 | Per-path flip-flop bypass |
| cfg_pack | input | 2 | Per-path direct capture of a spare line |
| out_top | output | 1 | Top routing output |
| out_bot | output | 1 | Bottom routing output |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
A wrong table index or a wrong mode decode shows on a bypassed path in the same cycle, and on a registered path one edge later. Random data lines reach it within a few cycles of each configuration. A flip-flop that loads while bypassed, or holds when it should load, stays hidden until bypass is cleared. The first registered cycle after that exposes the stale value, so the bench toggles bypass at random. A wrong legality rule shows at once as a mismatch on `cfg_err` and on the forced-low outputs.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    MODE_FULL6   = 2'd0,
    MODE_DUAL5   = 2'd1,
    MODE_MIX45   = 2'd2,
    MODE_SHARED6 = 2'd3
  } cell_mode_e;

  typedef struct packed {
    logic f1;
    logic e1;
    logic f0;
    logic e0;
    logic d;
    logic c;
    logic b;
    logic a;
  } cell_in_t;
endpackage

// File: rtl/flc_rst_sync.sv
module flc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/flc_lut_core.sv
module flc_lut_core
  import flc_pkg::*;
#(
  parameter int LUT_K = 6
) (
  input  logic [(1<<LUT_K)-1:0] mask,
  input  cell_mode_e            mode,
  input  logic                  pair_sel,
  input  logic                  share_b,
  input  cell_in_t              din,
  output logic [1:0]            y
);
  localparam int LUT_BITS  = 1 << LUT_K;
  localparam int HALF_BITS = LUT_BITS / 2;

  logic [HALF_BITS-1:0] tbl_lo;
  logic [HALF_BITS-1:0] tbl_hi;
  logic [5:0] idx_top6;
  logic [5:0] idx_bot6;
  logic [5:0] idx_full;
  logic [4:0] idx_lo5;
  logic [4:0] idx_hi5;
  logic [3:0] idx_hi4;
  logic       shared_line;
  logic       full_res;

  assign tbl_lo      = mask[HALF_BITS-1:0];
  assign tbl_hi      = mask[LUT_BITS-1:HALF_BITS];
  assign shared_line = share_b ? din.b : din.a;
  assign idx_top6    = {din.f0, din.e0, din.d, din.c, din.b, din.a};
  assign idx_bot6    = {din.f1, din.e1, din.d, din.c, din.b, din.a};
  assign idx_full    = pair_sel ? idx_bot6 : idx_top6;
  assign idx_lo5     = {din.e0, din.d, din.c, din.b, din.a};
  assign idx_hi5     = {din.f1, din.e1, din.f0, din.b, din.a};
  assign idx_hi4     = {din.f1, din.e1, din.f0, shared_line};
  assign full_res    = mask[idx_full];

  always_comb begin
    y = 2'b00;
    unique case (mode)
      MODE_FULL6: begin
        y[0] = full_res & ~pair_sel;
        y[1] = full_res &  pair_sel;
      end
      MODE_DUAL5: begin
        y[0] = tbl_lo[idx_lo5];
        y[1] = tbl_hi[idx_hi5];
      end
      MODE_MIX45: begin
        y[0] = tbl_lo[idx_lo5];
        y[1] = tbl_hi[{1'b0, idx_hi4}];
      end
      MODE_SHARED6: begin
        y[0] = mask[idx_top6];
        y[1] = mask[idx_bot6];
      end
      default: y = 2'b00;
    endcase
  end
endmodule

// File: rtl/flc_cfg_check.sv
module flc_cfg_check
  import flc_pkg::*;
(
  input  cell_mode_e mode,
  input  logic       pair_sel,
  input  logic [1:0] bypass,
  input  logic [1:0] pack,
  output logic       err
);
  logic whole_mode;
  logic pack0_legal;
  logic pack1_legal;
  logic pack_bypass_clash;

  assign whole_mode        = (mode == MODE_FULL6);
  assign pack0_legal       = whole_mode & pair_sel;
  assign pack1_legal       = whole_mode & ~pair_sel & bypass[0];
  assign pack_bypass_clash = |(pack & bypass);

  always_comb begin
    err = 1'b0;
    if (pack[0] && !pack0_legal) err = 1'b1;
    if (pack[1] && !pack1_legal) err = 1'b1;
    if (pack_bypass_clash)       err = 1'b1;
  end
endmodule

// File: rtl/flc_out_path.sv
module flc_out_path (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic bypass,
  input  logic kill,
  output logic q,
  output logic o
);
  logic q_en;
  logic q_nxt;

  assign q_en = ~bypass;

  always_comb begin
    q_nxt = q;
    if (q_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  always_comb begin
    if (kill)        o = 1'b0;
    else if (bypass) o = d;
    else             o = q;
  end
endmodule

// File: rtl/frac_lut_cell.sv
module frac_lut_cell
  import flc_pkg::*;
#(
  parameter int LUT_K       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_a,
  input  logic                  in_b,
  input  logic                  in_c,
  input  logic                  in_d,
  input  logic                  in_e0,
  input  logic                  in_f0,
  input  logic                  in_e1,
  input  logic                  in_f1,
  input  logic [(1<<LUT_K)-1:0] cfg_mask,
  input  logic [1:0]            cfg_mode,
  input  logic                  cfg_pair_sel,
  input  logic                  cfg_share_b,
  input  logic [1:0]            cfg_bypass,
  input  logic [1:0]            cfg_pack,
  output logic                  out_top,
  output logic                  out_bot,
  output logic                  cfg_err
);
  localparam int N_PATHS = 2;

  logic               rst_sync_n;
  cell_in_t           din;
  cell_mode_e         mode;
  logic [N_PATHS-1:0] lut_y;
  logic [N_PATHS-1:0] pack_src;
  logic [N_PATHS-1:0] path_d;
  logic [N_PATHS-1:0] path_q;
  logic [N_PATHS-1:0] path_o;

  assign din  = '{a: in_a, b: in_b, c: in_c, d: in_d,
                  e0: in_e0, f0: in_f0, e1: in_e1, f1: in_f1};
  assign mode = cell_mode_e'(cfg_mode);
  assign pack_src = {in_f1, in_e0};

  flc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flc_lut_core #(.LUT_K(LUT_K)) u_core (
    .mask     (cfg_mask),
    .mode     (mode),
    .pair_sel (cfg_pair_sel),
    .share_b  (cfg_share_b),
    .din      (din),
    .y        (lut_y)
  );

  flc_cfg_check u_check (
    .mode     (mode),
    .pair_sel (cfg_pair_sel),
    .bypass   (cfg_bypass),
    .pack     (cfg_pack),
    .err      (cfg_err)
  );

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    assign path_d[p] = cfg_pack[p] ? pack_src[p] : lut_y[p];

    flc_out_path u_path (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .d      (path_d[p]),
      .bypass (cfg_bypass[p]),
      .kill   (cfg_err),
      .q      (path_q[p]),
      .o      (path_o[p])
    );
  end

  assign out_top = path_o[0];
  assign out_bot = path_o[1];
endmodule

// File: rtl/flc_checker.sv
module flc_checker
  import flc_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic [1:0] cfg_mode,
  input logic       cfg_pair_sel,
  input logic [1:0] cfg_bypass,
  input logic [1:0] cfg_pack,
  input logic       in_e0,
  input logic       in_f0,
  input logic       in_e1,
  input logic       in_f1,
  input logic       out_top,
  input logic       out_bot,
  input logic       cfg_err,
  input logic [1:0] path_d,
  input logic [1:0] path_q
);
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_err |-> (!out_top && !out_bot)); // R11

  AST_PACK_BYPASS_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(cfg_pack & cfg_bypass)) |-> cfg_err); // R11

  AST_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(cfg_bypass[0])) |-> $stable(path_q[0])); // R8

  AST_LOAD_BOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$past(cfg_bypass[1])) |-> (path_q[1] == $past(path_d[1]))); // R8

  AST_IDLE_BOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_mode == MODE_FULL6 && !cfg_pair_sel && !cfg_pack[1] && cfg_bypass[1] && !cfg_err)
      |-> !out_bot); // R4

  AST_SHARED_EQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_mode == MODE_SHARED6 && cfg_bypass == 2'b11 && !cfg_err
       && in_e0 == in_e1 && in_f0 == in_f1) |-> (out_top == out_bot)); // R7
endmodule

bind frac_lut_cell flc_checker u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cfg_mode     (cfg_mode),
  .cfg_pair_sel (cfg_pair_sel),
  .cfg_bypass   (cfg_bypass),
  .cfg_pack     (cfg_pack),
  .in_e0        (in_e0),
  .in_f0        (in_f0),
  .in_e1        (in_e1),
  .in_f1        (in_f1),
  .out_top      (out_top),
  .out_bot      (out_bot),
  .cfg_err      (cfg_err),
  .path_d       (path_d),
  .path_q       (path_q)
);

// File: tb/frac_lut_cell_test.sv
`timescale 1ns/1ps
module frac_lut_cell_test;
  logic        clk;
  logic        rst_n;
  logic        in_a, in_b, in_c, in_d, in_e0, in_f0, in_e1, in_f1;
  logic [63:0] cfg_mask;
  logic [1:0]  cfg_mode;
  logic        cfg_pair_sel;
  logic        cfg_share_b;
  logic [1:0]  cfg_bypass;
  logic [1:0]  cfg_pack;
  logic        out_top, out_bot, cfg_err;

  int  n_checks;
  int  n_fails;
  bit  done;
  bit  model_en;
  bit  mq[2];
  bit  rand_bypass;

  frac_lut_cell uut (
    .clk(clk), .rst_n(rst_n),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .in_e0(in_e0), .in_f0(in_f0), .in_e1(in_e1), .in_f1(in_f1),
    .cfg_mask(cfg_mask), .cfg_mode(cfg_mode), .cfg_pair_sel(cfg_pair_sel),
    .cfg_share_b(cfg_share_b), .cfg_bypass(cfg_bypass), .cfg_pack(cfg_pack),
    .out_top(out_top), .out_bot(out_bot), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit mbit(int i);
    return cfg_mask[i];
  endfunction

  function automatic bit lut_res(int p);
    int a, b, c, d, e0, f0, e1, f1, s;
    a = in_a; b = in_b; c = in_c; d = in_d;
    e0 = in_e0; f0 = in_f0; e1 = in_e1; f1 = in_f1;
    s = cfg_share_b ? b : a;
    case (cfg_mode)
      2'd0: begin
        if (p == 0) return cfg_pair_sel ? 1'b0 : mbit(a + 2*b + 4*c + 8*d + 16*e0 + 32*f0);
        else        return cfg_pair_sel ? mbit(a + 2*b + 4*c + 8*d + 16*e1 + 32*f1) : 1'b0;
      end
      2'd1: begin
        if (p == 0) return mbit(a + 2*b + 4*c + 8*d + 16*e0);
        else        return mbit(32 + a + 2*b + 4*f0 + 8*e1 + 16*f1);
      end
      2'd2: begin
        if (p == 0) return mbit(a + 2*b + 4*c + 8*d + 16*e0);
        else        return mbit(32 + s + 2*f0 + 4*e1 + 8*f1);
      end
      default: begin
        if (p == 0) return mbit(a + 2*b + 4*c + 8*d + 16*e0 + 32*f0);
        else        return mbit(a + 2*b + 4*c + 8*d + 16*e1 + 32*f1);
      end
    endcase
  endfunction

  function automatic bit exp_d(int p);
    if (cfg_pack[p]) return (p == 0) ? in_e0 : in_f1;
    return lut_res(p);
  endfunction

  function automatic bit exp_err();
    bit e;
    e = 1'b0;
    if (cfg_pack[0] && !(cfg_mode == 2'd0 && cfg_pair_sel)) e = 1'b1;
    if (cfg_pack[1] && !(cfg_mode == 2'd0 && !cfg_pair_sel && cfg_bypass[0])) e = 1'b1;
    if (cfg_pack[0] && cfg_bypass[0]) e = 1'b1;
    if (cfg_pack[1] && cfg_bypass[1]) e = 1'b1;
    return e;
  endfunction

  function automatic bit exp_out(int p);
    if (exp_err()) return 1'b0;
    return cfg_bypass[p] ? exp_d(p) : mq[p];
  endfunction

  always @(posedge clk) begin
    if (model_en) begin
      for (int p = 0; p < 2; p++) begin
        if (!cfg_bypass[p]) mq[p] = exp_d(p);
      end
    end
  end

  task automatic chk(string tag, string what, bit act, bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic rand_data();
    {in_a, in_b, in_c, in_d, in_e0, in_f0, in_e1, in_f1} = 8'($urandom);
  endtask

  task automatic scenario(string tag, int mode, bit sel, bit shb,
                          bit [1:0] byp, bit [1:0] pk, int cycles);
    @(negedge clk);
    cfg_mask     = {$urandom, $urandom};
    cfg_mode     = 2'(mode);
    cfg_pair_sel = sel;
    cfg_share_b  = shb;
    cfg_bypass   = byp;
    cfg_pack     = pk;
    rand_data();
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(tag, "out_top", out_top, exp_out(0));
      chk(tag, "out_bot", out_bot, exp_out(1));
      chk(tag, "cfg_err", cfg_err, exp_err());
      rand_data();
      if (rand_bypass && !exp_err()) cfg_bypass = 2'($urandom);
      if (rand_bypass && exp_err())  cfg_bypass = byp;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0; model_en = 1'b0; rand_bypass = 1'b0;
    mq[0] = 1'b0; mq[1] = 1'b0;
    rst_n = 1'b0;
    cfg_mask = '1; cfg_mode = 2'd3; cfg_pair_sel = 1'b0; cfg_share_b = 1'b0;
    cfg_bypass = 2'b00; cfg_pack = 2'b00;
    {in_a, in_b, in_c, in_d, in_e0, in_f0, in_e1, in_f1} = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1", "out_top in reset", out_top, 1'b0);
    chk("R1", "out_bot in reset", out_bot, 1'b0);
    rand_data();
    @(negedge clk);
    chk("R1", "out_top in reset", out_top, 1'b0);
    chk("R1", "out_bot in reset", out_bot, 1'b0);
    cfg_mask = '0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    model_en = 1'b1;

    scenario("R2", 0, 1'b0, 1'b0, 2'b01, 2'b00, 24);
    scenario("R2", 0, 1'b0, 1'b0, 2'b00, 2'b00, 24);
    scenario("R3", 0, 1'b1, 1'b0, 2'b10, 2'b00, 24);
    scenario("R3", 0, 1'b1, 1'b0, 2'b00, 2'b00, 24);
    scenario("R4", 0, 1'b0, 1'b0, 2'b11, 2'b00, 16);
    scenario("R4", 0, 1'b1, 1'b0, 2'b11, 2'b00, 16);
    scenario("R5", 1, 1'b0, 1'b0, 2'b11, 2'b00, 32);
    scenario("R5", 1, 1'b1, 1'b1, 2'b00, 2'b00, 24);
    scenario("R6", 2, 1'b0, 1'b0, 2'b11, 2'b00, 32);
    scenario("R6", 2, 1'b0, 1'b1, 2'b11, 2'b00, 32);
    scenario("R6", 2, 1'b0, 1'b1, 2'b00, 2'b00, 16);
    scenario("R7", 3, 1'b0, 1'b0, 2'b11, 2'b00, 32);
    scenario("R7", 3, 1'b1, 1'b0, 2'b00, 2'b00, 16);
    rand_bypass = 1'b1;
    scenario("R8", 1, 1'b0, 1'b0, 2'b00, 2'b00, 48);
    scenario("R8", 3, 1'b0, 1'b0, 2'b00, 2'b00, 48);
    rand_bypass = 1'b0;
    scenario("R9", 0, 1'b1, 1'b0, 2'b00, 2'b01, 24);
    scenario("R9", 0, 1'b1, 1'b0, 2'b10, 2'b01, 24);
    scenario("R10", 0, 1'b0, 1'b0, 2'b01, 2'b10, 24);
    scenario("R11", 1, 1'b0, 1'b0, 2'b00, 2'b01, 12);
    scenario("R11", 0, 1'b0, 1'b0, 2'b00, 2'b01, 12);
    scenario("R11", 0, 1'b0, 1'b0, 2'b00, 2'b10, 12);
    scenario("R11", 0, 1'b1, 1'b0, 2'b01, 2'b01, 12);
    scenario("R11", 0, 1'b0, 1'b0, 2'b11, 2'b10, 12);
    scenario("R11", 3, 1'b0, 1'b0, 2'b10, 2'b10, 12);
    scenario("R2", 0, 1'b0, 1'b0, 2'b00, 2'b00, 12);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule